// File: doc/BRIEF.md
# Zoned Bandwidth Monitor

This block watches the traffic of one bus port. Each cycle the port may report an amount of data, measured in 64 kB units. The block adds these amounts over a programmable sampling window, which is counted in ticks of the monitor clock (a 19.2 MHz timer in the intended system).

When a window closes, the block places the window total in one of four zones using three thresholds. The total then drives three things:

- A programmable action map, which increments or clears the hit counter of each zone.
- A per-zone record of the largest total seen.
- A zone status bit, which is raised once a zone's hit counter reaches its programmed repeat count.

Enabled zone status bits feed a global interrupt level with its own enable and clear. Software reads the zone status and the maxima, clears the interrupts, moves the thresholds and restarts the monitor.

The register bus is a single-cycle write strobe with a combinational read. Offsets are byte addresses. Fields that software decodes keep fixed positions.

Top module: `bw_zone_monitor`

## Requirements
- R1: After reset the action map at 0x2B8 reads 0x95250901, the repeat counts at 0x2BC read 0xFFFFFFFF, zone status at 0x100 reads 0 and `irq` is low.
- R2: While bit 0 of 0x2A0 is set, strobe units are summed over windows of W clock ticks. W is the 20-bit value at 0x2A8, and a W of 0 acts as 1. The sum includes the strobe in the closing cycle, and the next window starts empty.
- R3: A window total T selects the zone as follows, with a total equal to a threshold placed in the higher zone:
  - zone 3 if T >= high (0x2AC);
  - else zone 2 if T >= medium (0x2B0);
  - else zone 1 if T >= low (0x2B4);
  - else zone 0.
- R4: For the selected zone k, byte k of the action map holds a 2-bit code for each target zone z at bits 2z+1:2z:
  - if bit 1 is set, hit counter z increments;
  - otherwise, if bit 0 is set, hit counter z clears;
  - a code of 0 leaves hit counter z unchanged.
- R5: Hit counters saturate at 255. They read back at 0x2D8, with zone z in byte z.
- R6: Zone z's status bit (bit 4+z of 0x100) sets when an increment leaves hit counter z at or above byte z of 0x2BC. Writing 1 to bit 4+z of 0x108 clears it, and a set in the same cycle wins over the clear.
- R7: The register at 0x2E0+4z holds the largest total-minus-one seen for zone z.
- R8: Zone status sets whatever the zone enables (bits 7:4 of 0x10C). Only enabled status bits make the local interrupt pending.
- R9: Global status (bit 0 of 0x0) sets whenever a local interrupt is pending. Writing 1 to bit 0 of 0x8 clears it only while nothing is pending. `irq` is global status AND bit 0 of 0xC.
- R10: Writing 1 to bit 0 of 0x2A4 zeroes the accumulator, the window timer, the hit counters and the maxima, and leaves zone status alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, one window tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| traffic_valid | input | 1 | Monitored port moved data this cycle |
| traffic_units | input | UNIT_W | Data moved this cycle, in 64 kB units |
| irq | output | 1 | Global interrupt level |

## Verification
The checker watches four things on every cycle:
- the global level retriggers while any enabled zone is pending;
- `irq` stays low without the global enable;
- hit counters only step by one or return to zero;
- a zone status bit only rises with its counter at or above its repeat count.

Which zone is chosen at an exact threshold, how a custom action map moves the counters, the minus-one convention of the maxima, saturation after hundreds of windows, and the behaviour of a zero window length are shown only by the bench scenarios. Those scenarios compare register reads against totals worked out from window length and strobe rate.

// File: rtl/bw_zone_monitor.sv
module bw_zone_monitor #(
  parameter int CNT_W  = 32,
  parameter int WIN_W  = 20,
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              traffic_valid,
  input  logic [UNIT_W-1:0] traffic_units,
  output logic              irq
);
  localparam int NZ = 4;
  localparam logic [31:0] ACT_RST = 32'h9525_0901;

  logic              en, gen, gstat;
  logic [WIN_W-1:0]  win_len, win_cnt;
  logic [CNT_W-1:0]  thr_hi, thr_med, thr_lo, acc;
  logic [31:0]       act_map, thr_cnt;
  logic [NZ-1:0][7:0]       hits, hits_nx;
  logic [NZ-1:0][CNT_W-1:0] zmax;
  logic [NZ-1:0]     zstat, zen, zset;
  logic [1:0]        zone;
  logic [7:0]        act;

  wire wr_clr   = reg_we && reg_addr == 12'h2A4 && reg_wdata[0];
  wire wr_zw1c  = reg_we && reg_addr == 12'h108;
  wire wr_gw1c  = reg_we && reg_addr == 12'h008 && reg_wdata[0];

  wire [CNT_W:0] sum = {1'b0, acc} +
       {{(CNT_W+1-UNIT_W){1'b0}}, {UNIT_W{traffic_valid}} & traffic_units};
  wire [CNT_W-1:0] total    = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  wire [CNT_W-1:0] total_m1 = (total == '0) ? '0 : total - 1'b1;
  wire expire = en && ({1'b0, win_cnt} + 1'b1 >= {1'b0, win_len});
  wire local_pend = |(zstat & zen);

  assign irq = gstat & gen;

  always_comb begin
    if (total >= thr_hi)       zone = 2'd3;
    else if (total >= thr_med) zone = 2'd2;
    else if (total >= thr_lo)  zone = 2'd1;
    else                       zone = 2'd0;
    act = act_map[8*zone +: 8];
    for (int t = 0; t < NZ; t++) begin
      hits_nx[t] = hits[t];
      zset[t]    = 1'b0;
      if (act[2*t+1]) begin
        hits_nx[t] = (hits[t] == 8'hFF) ? 8'hFF : hits[t] + 8'd1;
        zset[t]    = expire && (hits_nx[t] >= thr_cnt[8*t +: 8]);
      end else if (act[2*t]) begin
        hits_nx[t] = 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; gen <= 1'b0; gstat <= 1'b0;
      win_len <= '0; win_cnt <= '0; acc <= '0;
      thr_hi <= '0; thr_med <= '0; thr_lo <= '0;
      act_map <= ACT_RST; thr_cnt <= '1;
      hits <= '0; zmax <= '0; zstat <= '0; zen <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          12'h00C: gen     <= reg_wdata[0];
          12'h10C: zen     <= reg_wdata[7:4];
          12'h2A0: en      <= reg_wdata[0];
          12'h2A8: win_len <= reg_wdata[WIN_W-1:0];
          12'h2AC: thr_hi  <= reg_wdata[CNT_W-1:0];
          12'h2B0: thr_med <= reg_wdata[CNT_W-1:0];
          12'h2B4: thr_lo  <= reg_wdata[CNT_W-1:0];
          12'h2B8: act_map <= reg_wdata;
          12'h2BC: thr_cnt <= reg_wdata;
          default: ;
        endcase
      end
      gstat <= (gstat & ~wr_gw1c) | local_pend;
      zstat <= (zstat & ~({NZ{wr_zw1c}} & reg_wdata[7:4])) | zset;
      if (wr_clr) begin
        acc <= '0; win_cnt <= '0; hits <= '0; zmax <= '0;
      end else if (expire) begin
        acc <= '0; win_cnt <= '0; hits <= hits_nx;
        if (total_m1 > zmax[zone]) zmax[zone] <= total_m1;
      end else if (en) begin
        acc <= total; win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      12'h000: reg_rdata = {31'd0, gstat};
      12'h00C: reg_rdata = {31'd0, gen};
      12'h100: reg_rdata = {24'd0, zstat, 4'd0};
      12'h10C: reg_rdata = {24'd0, zen, 4'd0};
      12'h2A0: reg_rdata = {31'd0, en};
      12'h2A8: reg_rdata = 32'(win_len);
      12'h2AC: reg_rdata = 32'(thr_hi);
      12'h2B0: reg_rdata = 32'(thr_med);
      12'h2B4: reg_rdata = 32'(thr_lo);
      12'h2B8: reg_rdata = act_map;
      12'h2BC: reg_rdata = thr_cnt;
      12'h2D8: reg_rdata = hits;
      12'h2E0: reg_rdata = 32'(zmax[0]);
      12'h2E4: reg_rdata = 32'(zmax[1]);
      12'h2E8: reg_rdata = 32'(zmax[2]);
      12'h2EC: reg_rdata = 32'(zmax[3]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bw_zone_monitor_chk.sv
module bw_zone_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        local_pend,
  input logic        gstat,
  input logic        gen,
  input logic        irq,
  input logic [31:0] hits,
  input logic [3:0]  zstat,
  input logic [31:0] thr_cnt
);
  // R9
  retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_pend |=> gstat);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> !irq);

  for (genvar z = 0; z < 4; z++) begin : g_zone
    // R5
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hits[8*z +: 8] != $past(hits[8*z +: 8])) |->
        (hits[8*z +: 8] == $past(hits[8*z +: 8]) + 8'd1 || hits[8*z +: 8] == 8'd0));

    // R6
    status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zstat[z]) |-> (hits[8*z +: 8] >= thr_cnt[8*z +: 8]));
  end
endmodule

bind bw_zone_monitor bw_zone_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .local_pend(local_pend), .gstat(gstat),
  .gen(gen), .irq(irq), .hits(hits), .zstat(zstat), .thr_cnt(thr_cnt)
);

// File: tb/bw_zone_monitor_tb.sv
module bw_zone_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        traffic_valid = 1'b0;
  logic [7:0]  traffic_units = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  bw_zone_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .traffic_valid(traffic_valid), .traffic_units(traffic_units), .irq(irq)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  // enabled for n+2 counting edges
  task automatic run(input int n);
    wr(12'h2A0, 1);
    repeat (n) @(posedge clk);
    wr(12'h2A0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(12'h2B8, 32'h9525_0901, "R1 action map");
    chk(12'h2BC, 32'hFFFF_FFFF, "R1 repeat counts");
    chk(12'h100, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");

    // 4-tick windows, 20 units each, equal to medium -> zone 2
    wr(12'h2A8, 4);
    wr(12'h2B4, 10); wr(12'h2B0, 20); wr(12'h2AC, 30);
    wr(12'h2BC, 32'h0102_FFFF);
    wr(12'h10C, 32'h40); wr(12'h00C, 1);
    traffic_valid = 1'b1; traffic_units = 8'd5;
    run(10);
    chk(12'h2D8, 32'h0003_0000, "R3 R4 zone2 hits");
    chk(12'h100, 32'h40, "R6 zone2 status");
    chk(12'h2E8, 32'd19, "R7 zone2 max");
    chk(12'h000, 32'h1, "R9 global status");
    chk_irq(1'b1, "R9 irq");
    wr(12'h008, 1);
    chk(12'h000, 32'h1, "R9 retrigger");
    wr(12'h108, 32'h40);
    chk(12'h100, 32'h0, "R6 w1c");
    wr(12'h008, 1);
    chk(12'h000, 32'h0, "R9 global clear");
    chk_irq(1'b0, "R9 irq low");

    // counter clear, then zone 3 with only zone 1 enabled
    wr(12'h2A4, 1);
    chk(12'h2D8, 32'h0, "R10 hits cleared");
    chk(12'h2E8, 32'h0, "R10 max cleared");
    wr(12'h10C, 32'h20);
    traffic_units = 8'd10;
    run(10);
    chk(12'h100, 32'h80, "R8 status without enable");
    chk_irq(1'b0, "R8 masked irq");
    chk(12'h000, 32'h0, "R8 global not set");
    chk(12'h2D8, 32'h0300_0000, "R4 zone3 clears lower");
    chk(12'h2EC, 32'd39, "R7 zone3 max");
    wr(12'h10C, 32'h80);
    chk_irq(1'b1, "R8 enabled irq");
    wr(12'h2A4, 1);
    chk(12'h100, 32'h80, "R10 status kept");

    // custom map: zone 1 increments zone 0 only
    wr(12'h108, 32'hF0); wr(12'h008, 1);
    wr(12'h2B8, 32'h0000_0200);
    wr(12'h2BC, 32'hFFFF_FF03);
    traffic_units = 8'd3;
    run(10);
    chk(12'h2D8, 32'h0000_0003, "R4 custom map");
    chk(12'h100, 32'h10, "R6 zone0 status");
    chk(12'h2E4, 32'd11, "R3 R7 zone1 max");

    // saturation with 1-tick windows
    wr(12'h108, 32'hF0);
    wr(12'h2A4, 1);
    wr(12'h2B8, 32'h9525_0901);
    wr(12'h2A8, 1);
    traffic_units = 8'd40;
    run(298);
    chk(12'h2D8, 32'hFF00_0000, "R5 saturation");

    // zero window length acts as one tick
    wr(12'h2A4, 1);
    wr(12'h2A8, 0);
    run(3);
    chk(12'h2D8, 32'h0500_0000, "R2 zero window");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule